// File: doc/BRIEF.md
# Supply Mode and Backup Controller

This block turns the decoded bits of a pager power subsystem's control registers, together with three external pins, into the enable signals of the power stage. It picks between full-power run mode and low-current coast mode. It decides whether the boost converter or the backup linear regulator drives the main output, and it selects the charge current. It also gates the two open-drain drivers, switches the auxiliary regulators, clamps the logic rail when the main output is programmed high, and powers the threshold DAC and its comparators.

The RUN pin, the beeper gating pin and the low-battery comparator output are asynchronous. Each passes through a two-stage synchronizer before it is used. Every enable leaves the block from a register. A control-bit change therefore shows at the outputs one clock later, and a pin change shows three clocks later. An active-low reset puts every enable into its power-up state.

Top module: `pm_supply_ctrl`

## Requirements
- R1: `run_mode` is 1 when the synchronized RUN pin or `ctl_run` is 1. It is 0 (coast) only when both are 0.
- R2: `backup_en` is 1 when `ctl_backup` is 1, or when `ctl_auto_backup` is 1 and the synchronized `lowbatt_n` is 0 (low battery).
- R3: While `backup_en` is 1, `conv_en` is 0 and `chg_sel` is 2'b00. Otherwise `conv_en` is 1.
- R4: `chg_sel` encodes the charger: 2'b00 off, 2'b01 low current (`ctl_chg_low`), 2'b10 high current (`ctl_chg_high`). When both bits are set, 2'b10 wins. The value 2'b11 never appears.
- R5: `drv1_gate` follows `ctl_drv1`. `drv2_gate` is 1 only when `ctl_drv2` and the synchronized `beep_gate` are both 1.
- R6: `rail_clamp_en` is 1 when `ctl_vout_code` is 16 or more (3.4 V and above) and 0 below that.
- R7: `cmp_pwr_en` is 0 when `ctl_dac_code` is all zeros and 1 for any other code.
- R8: While `rst_n` is low, and in the first cycle after it, the outputs are: coast mode, converter on, backup off, charger off, both drivers off, regulators off, clamp off, comparators off. The synchronizers read as RUN low, gate low, battery good.
- R9: A change on a control bit reaches the outputs on the next rising edge. A change on a pin reaches them on the third rising edge.
- R10: `reg2_en` follows `ctl_reg2` and `reg3_en` follows `ctl_reg3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_run | input | 1 | Run/coast control bit |
| ctl_drv1 | input | 1 | Driver 1 on bit |
| ctl_drv2 | input | 1 | Driver 2 on bit |
| ctl_reg2 | input | 1 | Analog regulator on bit |
| ctl_reg3 | input | 1 | 1 V regulator on bit |
| ctl_chg_low | input | 1 | Low charge current bit |
| ctl_chg_high | input | 1 | High charge current bit |
| ctl_backup | input | 1 | Backup regulator force bit |
| ctl_auto_backup | input | 1 | Arm backup from low battery |
| ctl_vout_code | input | 5 | Output-voltage code |
| ctl_dac_code | input | 7 | Threshold DAC code |
| run_pin | input | 1 | Asynchronous RUN pin |
| beep_gate | input | 1 | Asynchronous driver 2 gating pin |
| lowbatt_n | input | 1 | Low-battery comparator output, low = battery low |
| run_mode | output | 1 | 1 run, 0 coast |
| conv_en | output | 1 | Boost converter enable |
| backup_en | output | 1 | Backup regulator enable |
| chg_sel | output | 2 | Charge current select |
| drv1_gate | output | 1 | Driver 1 gate |
| drv2_gate | output | 1 | Driver 2 gate |
| reg2_en | output | 1 | Analog regulator enable |
| reg3_en | output | 1 | 1 V regulator enable |
| rail_clamp_en | output | 1 | Logic-rail clamp enable |
| cmp_pwr_en | output | 1 | Threshold DAC and comparator power |

## Verification
The bench targets the points where an error would not show in ordinary use. One is auto-backup driven only by the low-battery pin. A design that ignored it would keep the converter and charger running from a failing cell. Another is both charge bits set while backup is active: a wrong priority would drive 2'b11 or leave the charger on in backup. The bench also tries vout codes 15 and 16 at the clamp boundary and DAC code zero against code one. Pin edges are checked against the three-cycle latency, so a missing or extra synchronizer stage shows up as a mismatch in a single cycle. A reset pulse in the middle of a run checks that everything returns to coast with the converter on.

// File: rtl/pm_supply_pkg.sv
package pm_supply_pkg;

  typedef enum logic [1:0] {
    CHG_OFF  = 2'b00,
    CHG_LOW  = 2'b01,
    CHG_HIGH = 2'b10
  } chg_sel_e;

  typedef struct packed {
    logic     run;
    logic     conv;
    logic     backup;
    chg_sel_e chg;
    logic     drv1;
    logic     drv2;
    logic     reg2;
    logic     reg3;
    logic     clamp;
    logic     cmp_pwr;
  } pm_enables_t;

  localparam pm_enables_t PM_RESET = '{
    run: 1'b0, conv: 1'b1, backup: 1'b0, chg: CHG_OFF,
    drv1: 1'b0, drv2: 1'b0, reg2: 1'b0, reg3: 1'b0,
    clamp: 1'b0, cmp_pwr: 1'b0
  };

  function automatic logic pick_run(input logic bit_run, input logic pin_run);
    return bit_run | pin_run;
  endfunction

  function automatic logic pick_backup(input logic force_bk, input logic arm_auto,
                                       input logic batt_ok);
    return force_bk | (arm_auto & ~batt_ok);
  endfunction

  function automatic chg_sel_e pick_charge(input logic hi, input logic lo,
                                           input logic bk);
    if (bk)      return CHG_OFF;
    else if (hi) return CHG_HIGH;
    else if (lo) return CHG_LOW;
    else         return CHG_OFF;
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_decode.sv
module pm_decode
  import pm_supply_pkg::*;
#(
  parameter int VOUT_W     = 5,
  parameter int DAC_W      = 7,
  parameter int CLAMP_CODE = 16
) (
  input  logic              ctl_run,
  input  logic              ctl_drv1,
  input  logic              ctl_drv2,
  input  logic              ctl_reg2,
  input  logic              ctl_reg3,
  input  logic              ctl_chg_low,
  input  logic              ctl_chg_high,
  input  logic              ctl_backup,
  input  logic              ctl_auto_backup,
  input  logic [VOUT_W-1:0] ctl_vout_code,
  input  logic [DAC_W-1:0]  ctl_dac_code,
  input  logic              run_s,
  input  logic              gate_s,
  input  logic              batt_ok_s,
  output pm_enables_t       nxt
);
  localparam logic [VOUT_W-1:0] CLAMP_THR = VOUT_W'(CLAMP_CODE);

  logic bk_want;

  always_comb begin
    bk_want     = pick_backup(ctl_backup, ctl_auto_backup, batt_ok_s);
    nxt.run     = pick_run(ctl_run, run_s);
    nxt.backup  = bk_want;
    nxt.conv    = ~bk_want;
    nxt.chg     = pick_charge(ctl_chg_high, ctl_chg_low, bk_want);
    nxt.drv1    = ctl_drv1;
    nxt.drv2    = ctl_drv2 & gate_s;
    nxt.reg2    = ctl_reg2;
    nxt.reg3    = ctl_reg3;
    nxt.clamp   = (ctl_vout_code >= CLAMP_THR);
    nxt.cmp_pwr = |ctl_dac_code;
  end
endmodule

// File: rtl/pm_out_reg.sv
module pm_out_reg
  import pm_supply_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pm_enables_t d,
  output pm_enables_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PM_RESET;
    else        q <= d;
  end
endmodule

// File: rtl/pm_supply_ctrl.sv
module pm_supply_ctrl
  import pm_supply_pkg::*;
#(
  parameter int VOUT_W      = 5,
  parameter int DAC_W       = 7,
  parameter int CLAMP_CODE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_run,
  input  logic              ctl_drv1,
  input  logic              ctl_drv2,
  input  logic              ctl_reg2,
  input  logic              ctl_reg3,
  input  logic              ctl_chg_low,
  input  logic              ctl_chg_high,
  input  logic              ctl_backup,
  input  logic              ctl_auto_backup,
  input  logic [VOUT_W-1:0] ctl_vout_code,
  input  logic [DAC_W-1:0]  ctl_dac_code,
  input  logic              run_pin,
  input  logic              beep_gate,
  input  logic              lowbatt_n,
  output logic              run_mode,
  output logic              conv_en,
  output logic              backup_en,
  output logic [1:0]        chg_sel,
  output logic              drv1_gate,
  output logic              drv2_gate,
  output logic              reg2_en,
  output logic              reg3_en,
  output logic              rail_clamp_en,
  output logic              cmp_pwr_en
);
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b100;
  localparam logic [VOUT_W-1:0] CLAMP_THR = VOUT_W'(CLAMP_CODE);

  logic [PIN_N-1:0] pins_raw, pins_s;
  logic run_s, gate_s, batt_ok_s;
  pm_enables_t en_nxt, en_q;

  assign pins_raw = {lowbatt_n, beep_gate, run_pin};

  pm_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign run_s     = pins_s[0];
  assign gate_s    = pins_s[1];
  assign batt_ok_s = pins_s[2];

  pm_decode #(.VOUT_W(VOUT_W), .DAC_W(DAC_W), .CLAMP_CODE(CLAMP_CODE)) u_dec (
    .ctl_run(ctl_run), .ctl_drv1(ctl_drv1), .ctl_drv2(ctl_drv2),
    .ctl_reg2(ctl_reg2), .ctl_reg3(ctl_reg3),
    .ctl_chg_low(ctl_chg_low), .ctl_chg_high(ctl_chg_high),
    .ctl_backup(ctl_backup), .ctl_auto_backup(ctl_auto_backup),
    .ctl_vout_code(ctl_vout_code), .ctl_dac_code(ctl_dac_code),
    .run_s(run_s), .gate_s(gate_s), .batt_ok_s(batt_ok_s),
    .nxt(en_nxt)
  );

  pm_out_reg u_oreg (.clk(clk), .rst_n(rst_n), .d(en_nxt), .q(en_q));

  assign run_mode      = en_q.run;
  assign conv_en       = en_q.conv;
  assign backup_en     = en_q.backup;
  assign chg_sel       = en_q.chg;
  assign drv1_gate     = en_q.drv1;
  assign drv2_gate     = en_q.drv2;
  assign reg2_en       = en_q.reg2;
  assign reg3_en       = en_q.reg3;
  assign rail_clamp_en = en_q.clamp;
  assign cmp_pwr_en    = en_q.cmp_pwr;

  // Checks next to the output register; each relates outputs to the inputs
  // seen one edge earlier.
  a_r8_reset_state: assert property (@(posedge clk)
    !rst_n |=> (conv_en && !run_mode && !backup_en && chg_sel == 2'b00 &&
                !drv1_gate && !drv2_gate && !rail_clamp_en && !cmp_pwr_en));

  a_r1_coast_needs_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctl_run)) |-> run_mode);

  a_r2_forced_backup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctl_backup)) |-> backup_en);

  a_r3_backup_excludes: assert property (@(posedge clk) disable iff (!rst_n)
    backup_en |-> (!conv_en && chg_sel == 2'b00));

  a_r4_no_code_three: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg_sel));

  a_r5_drv2_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && drv2_gate) |-> ($past(ctl_drv2) && $past(gate_s)));

  a_r6_clamp_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rail_clamp_en == ($past(ctl_vout_code) >= CLAMP_THR)));

  a_r7_dac_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctl_dac_code) == '0) |-> !cmp_pwr_en);

endmodule

// File: tb/pm_supply_ctrl_test.sv
module pm_supply_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic c_run, c_d1, c_d2, c_r2, c_r3, c_lo, c_hi, c_bk, c_auto;
  logic [4:0] c_vout;
  logic [6:0] c_dac;
  logic p_run, p_gate, p_lbn;
  logic o_run, o_conv, o_bk, o_d1, o_d2, o_r2, o_r3, o_clamp, o_cmp;
  logic [1:0] o_chg;

  pm_supply_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_run(c_run), .ctl_drv1(c_d1), .ctl_drv2(c_d2),
    .ctl_reg2(c_r2), .ctl_reg3(c_r3), .ctl_chg_low(c_lo), .ctl_chg_high(c_hi),
    .ctl_backup(c_bk), .ctl_auto_backup(c_auto), .ctl_vout_code(c_vout),
    .ctl_dac_code(c_dac), .run_pin(p_run), .beep_gate(p_gate), .lowbatt_n(p_lbn),
    .run_mode(o_run), .conv_en(o_conv), .backup_en(o_bk), .chg_sel(o_chg),
    .drv1_gate(o_d1), .drv2_gate(o_d2), .reg2_en(o_r2), .reg3_en(o_r3),
    .rail_clamp_en(o_clamp), .cmp_pwr_en(o_cmp)
  );

  typedef struct {
    bit rst; bit run; bit d1; bit d2; bit r2; bit r3; bit lo; bit hi; bit bk; bit au;
    int vout; int dac; bit prun; bit pgate; bit plbn;
  } snap_t;

  snap_t hist[$];
  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, nm, cycles, act, exp);
    end
  endtask

  // Reference model: control bits act one edge later, pins three edges later.
  always @(posedge clk) begin
    snap_t s;
    bit e_run, e_conv, e_bk, e_d1, e_d2, e_r2, e_r3, e_clamp, e_cmp;
    int e_chg;
    bit pr, pg, pl;
    string tag;
    s.rst = rst_n; s.run = c_run; s.d1 = c_d1; s.d2 = c_d2; s.r2 = c_r2; s.r3 = c_r3;
    s.lo = c_lo; s.hi = c_hi; s.bk = c_bk; s.au = c_auto; s.vout = c_vout; s.dac = c_dac;
    s.prun = p_run; s.pgate = p_gate; s.plbn = p_lbn;
    hist.push_front(s);
    if (hist.size() > 4) void'(hist.pop_back());
    cycles++;
    #2;
    if (!hist[0].rst) begin
      e_run = 0; e_conv = 1; e_bk = 0; e_chg = 0; e_d1 = 0; e_d2 = 0;
      e_r2 = 0; e_r3 = 0; e_clamp = 0; e_cmp = 0;
      tag = "R8";
    end else begin
      if (hist.size() >= 3 && hist[1].rst && hist[2].rst) begin
        pr = hist[2].prun; pg = hist[2].pgate; pl = hist[2].plbn;
      end else begin
        pr = 0; pg = 0; pl = 1;
      end
      e_run = hist[0].run || pr;
      e_bk = hist[0].bk || (hist[0].au && !pl);
      e_conv = !e_bk;
      e_chg = e_bk ? 0 : (hist[0].hi ? 2 : (hist[0].lo ? 1 : 0));
      e_d1 = hist[0].d1; e_d2 = hist[0].d2 && pg;
      e_r2 = hist[0].r2; e_r3 = hist[0].r3;
      e_clamp = hist[0].vout >= 16; e_cmp = hist[0].dac != 0;
      tag = "";
    end
    cmp(tag == "" ? "R1/R9" : "R8", "run_mode", o_run, e_run);
    cmp(tag == "" ? "R2" : "R8", "backup_en", o_bk, e_bk);
    cmp(tag == "" ? "R3" : "R8", "conv_en", o_conv, e_conv);
    cmp(tag == "" ? "R4" : "R8", "chg_sel", o_chg, e_chg);
    cmp(tag == "" ? "R5" : "R8", "drv1_gate", o_d1, e_d1);
    cmp(tag == "" ? "R5" : "R8", "drv2_gate", o_d2, e_d2);
    cmp(tag == "" ? "R10" : "R8", "reg2_en", o_r2, e_r2);
    cmp(tag == "" ? "R10" : "R8", "reg3_en", o_r3, e_r3);
    cmp(tag == "" ? "R6" : "R8", "rail_clamp_en", o_clamp, e_clamp);
    cmp(tag == "" ? "R7" : "R8", "cmp_pwr_en", o_cmp, e_cmp);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_ctl();
    c_run = 0; c_d1 = 0; c_d2 = 0; c_r2 = 0; c_r3 = 0; c_lo = 0; c_hi = 0;
    c_bk = 0; c_auto = 0; c_vout = 5'd12; c_dac = 7'd0;
  endtask

  initial begin
    rst_n = 0; clear_ctl(); p_run = 0; p_gate = 0; p_lbn = 1;
    // R8: inputs that would enable everything are held during reset
    c_run = 1; c_d1 = 1; c_bk = 1; c_vout = 5'd20; c_dac = 7'd9; p_run = 1;
    idle(4);
    clear_ctl(); p_run = 0;
    rst_n = 1;
    idle(5);
    // R1/R9: RUN pin edge lands on the third edge
    p_run = 1; idle(6); p_run = 0; idle(6);
    c_run = 1; idle(3); c_run = 0; idle(3);
    // R2/R3: auto backup armed, low battery pin asserted
    c_auto = 1; c_hi = 1; c_lo = 1; idle(4);
    p_lbn = 0; idle(6); p_lbn = 1; idle(6);
    c_auto = 0; p_lbn = 0; idle(6); p_lbn = 1;
    // R2/R4: forced backup with both charge bits, then release
    c_bk = 1; idle(3); c_bk = 0; idle(3); c_hi = 0; idle(3); c_lo = 0; idle(3);
    // R5: driver 2 gating
    c_d2 = 1; idle(3); p_gate = 1; idle(5); c_d2 = 0; idle(3); c_d2 = 1; p_gate = 0; idle(5);
    c_d1 = 1; idle(2); c_d1 = 0; c_d2 = 0;
    // R6: clamp boundary
    c_vout = 5'd15; idle(2); c_vout = 5'd16; idle(2); c_vout = 5'd31; idle(2); c_vout = 5'd0; idle(2);
    // R7: DAC zero versus one
    c_dac = 7'd1; idle(2); c_dac = 7'd0; idle(2); c_dac = 7'd127; idle(2);
    // R10
    c_r2 = 1; idle(2); c_r3 = 1; c_r2 = 0; idle(2);
    // Random phase with pins held for a few cycles
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      {c_run, c_d1, c_d2, c_r2, c_r3, c_lo, c_hi} = 7'($urandom);
      c_bk = ($urandom % 4) == 0; c_auto = $urandom;
      c_vout = 5'($urandom); c_dac = ($urandom % 3 == 0) ? 7'd0 : 7'($urandom);
      if (i % 3 == 0) {p_run, p_gate, p_lbn} = 3'($urandom);
      if (i == 700) rst_n = 0;
      if (i == 703) rst_n = 1;
    end
    idle(5);
    done = 1;
  end

  initial begin
    wait (done || cycles > 50000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule